// File: doc/BRIEF.md
# Memory Bit Test-and-Modify Unit

This block carries out the two bit-manipulating read-modify-write operations of a small accumulator-based processor datapath: test-and-clear and test-and-set. The sequencer hands it an operand address, a mask taken from the accumulator, an operation select and a width mode, then pulses `start`. The unit reads the operand through a byte-wide synchronous memory port and updates a zero flag. The flag is derived from the mask ANDed with the value as it was read, so it reports the state of the location before the change. The unit then writes back the operand with the masked bits either cleared or set.

In narrow mode one byte is handled. In wide mode a 16-bit operand is handled as two consecutive bytes: the low byte at the given address and the high byte at the next one. The address may lie anywhere in the address space, and address+1 wraps at the top. `busy` covers the whole sequence and `done` marks its last cycle. The zero flag is held until the next operation updates it.

Top module: `tbm_unit`

## Requirements
- R1: `zero` becomes 1 when (operand read from memory AND effective mask) is all zeros and 0 otherwise, using the value before write-back. It is updated once per operation, is visible when `done` is high, and holds until the next operation updates it.
- R2: With `op_set`=0 (clear variant), each byte written back equals the read byte AND NOT the corresponding mask byte.
- R3: With `op_set`=1 (set variant), each byte written back equals the read byte OR the corresponding mask byte.
- R4: With `narrow`=1 the operation uses 8 bits: one read and one write at `addr`, and `mask[15:8]` has no effect on either `zero` or memory. The byte at `addr`+1 is not touched.
- R5: With `narrow`=0 the operation uses 16 bits: the low byte comes from `addr` and the high byte from `addr`+1, modulo 2^AW. Both bytes are read low first and written back low first.
- R6: Any address in the full AW-bit space works, including addresses above the first 256 bytes and the topmost address.
- R7: `done` is a single-cycle pulse. It is high in the 5th (narrow) or 7th (wide) clock cycle, counting the edge that samples `start` as the 1st. `busy` is high from the cycle after that edge through the `done` cycle, and low in the cycle after.
- R8: The write-back always happens, even when the mask leaves the value unchanged. Each operation makes exactly 1 (narrow) or 2 (wide) writes.
- R9: While `rst_n` is low at a clock edge, the unit returns to idle. After that edge `busy`, `done`, `mem_rd`, `mem_wr` and `zero` are 0, and this applies in the middle of an operation too.
- R10: `start` and the request inputs are ignored while `busy` is high. They cause no extra memory access, and the operation in progress uses the values captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_set | input | 1 | 1 = set masked bits, 0 = clear masked bits |
| narrow | input | 1 | 1 = 8-bit operand, 0 = 16-bit operand |
| mask | input | 16 | Accumulator mask (low byte only in narrow mode) |
| addr | input | AW (16) | Operand address (low byte in wide mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zero | output | 1 | Zero flag from mask AND prior operand |
| mem_addr | output | AW (16) | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
Several kinds of operand and mask pair are tried. Disjoint pairs show that `zero` is 1 and that the clear variant leaves memory as it was. Overlapping pairs show that `zero` is 0 and that the masked bits flip. A zero mask shows that the write-back happens even when nothing changes. A narrow case carries a non-zero mask high byte, which shows that those bits are ignored. Wide cases with the mask only in the high byte, or with the address at the top of the space, show byte order and wrap-around. Both variants are run on the same kinds of data so that a swapped operation is caught.

// File: rtl/tbm_pkg.sv
// Shared types for the bit test-and-modify unit.
// Assumes: at most eight sequencer states; the operation select is one bit.
package tbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_RDL,    // read strobe, low byte address
        ST_RDH,    // read strobe, high byte address (wide only)
        ST_CAP,    // capture last returned byte
        ST_CMP,    // update the zero flag
        ST_WRL,    // write low byte
        ST_WRH,    // write high byte (wide only)
        ST_FIN     // done pulse
    } tbm_state_e;

    typedef enum logic {
        OP_CLEAR = 1'b0,
        OP_SET   = 1'b1
    } tbm_op_e;

endpackage

// File: rtl/tbm_ctrl.sv
// Sequencer for the read-compute-write pass of the bit test-and-modify unit.
// Assumes: memory read data returns one cycle after the read strobe;
// narrow_i is the value latched with the request, stable while busy.
module tbm_ctrl
    import tbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic narrow_i,
    output logic load_o,
    output logic busy_o,
    output logic done_o,
    output logic rd_o,
    output logic wr_o,
    output logic sel_hi_o,
    output logic cap_lo_o,
    output logic cap_hi_o,
    output logic upd_z_o
);

    tbm_state_e state_q, state_d;
    logic [1:0] wr_cnt_q;

    // Next-state selection for the access sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RDL;
            ST_RDL:  state_d = narrow_i ? ST_CAP : ST_RDH;
            ST_RDH:  state_d = ST_CAP;
            ST_CAP:  state_d = ST_CMP;
            ST_CMP:  state_d = ST_WRL;
            ST_WRL:  state_d = narrow_i ? ST_FIN : ST_WRH;
            ST_WRH:  state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decode strobes and capture enables from the current state.
    always_comb begin
        load_o   = (state_q == ST_IDLE) && start_i;
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_FIN);
        rd_o     = (state_q == ST_RDL) || (state_q == ST_RDH);
        wr_o     = (state_q == ST_WRL) || (state_q == ST_WRH);
        sel_hi_o = (state_q == ST_RDH) || (state_q == ST_WRH);
        cap_lo_o = (state_q == ST_RDH) || ((state_q == ST_CAP) && narrow_i);
        cap_hi_o = (state_q == ST_CAP) && !narrow_i;
        upd_z_o  = (state_q == ST_CMP);
    end

    // Count write strobes of the current operation for the write-count check.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_cnt_q <= '0;
        else if (load_o) wr_cnt_q <= '0;
        else if (wr_o)   wr_cnt_q <= wr_cnt_q + 2'd1;
    end

    // R7: done lasts exactly one cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done only appears inside a busy window.
    a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R8: each operation ends with one write per byte of its width.
    a_r8_write_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_cnt_q == (narrow_i ? 2'd1 : 2'd2)));

    // R9: no memory strobe while idle.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_o && !wr_o));

endmodule

// File: rtl/tbm_opreg.sv
// Request latch and operand capture for the bit test-and-modify unit.
// Latches address, operation, width and mask on load; in narrow mode the
// mask lanes above the first are forced to zero. Each byte lane captures
// returned read data on its own enable.
// Assumes: load_i and the capture enables are never high together.
module tbm_opreg
    import tbm_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int NB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             busy_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [NB*DW-1:0] mask_i,
    input  logic             op_set_i,
    input  logic             narrow_i,
    input  logic [NB-1:0]    cap_i,
    input  logic [DW-1:0]    rdata_i,
    output logic [AW-1:0]    base_o,
    output tbm_op_e          op_o,
    output logic             narrow_o,
    output logic [NB*DW-1:0] mask_o,
    output logic [NB*DW-1:0] opnd_o
);

    logic [AW-1:0] base_q;
    tbm_op_e       op_q;
    logic          narrow_q;
    logic [DW-1:0] opnd_q [NB];
    logic [DW-1:0] mask_q [NB];

    // Latch the request fields when a new operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            op_q     <= OP_CLEAR;
            narrow_q <= 1'b0;
        end else if (load_i) begin
            base_q   <= addr_i;
            op_q     <= op_set_i ? OP_SET : OP_CLEAR;
            narrow_q <= narrow_i;
        end
    end

    for (genvar k = 0; k < NB; k++) begin : g_lane
        // Per-lane mask latch and operand byte capture.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opnd_q[k] <= '0;
                mask_q[k] <= '0;
            end else if (load_i) begin
                opnd_q[k] <= '0;
                mask_q[k] <= (narrow_i && (k != 0)) ? '0 : mask_i[k*DW +: DW];
            end else if (cap_i[k]) begin
                opnd_q[k] <= rdata_i;
            end
        end
        assign opnd_o[k*DW +: DW] = opnd_q[k];
        assign mask_o[k*DW +: DW] = mask_q[k];
    end

    assign base_o   = base_q;
    assign op_o     = op_q;
    assign narrow_o = narrow_q;

    // R10: the latched address cannot move while an operation runs.
    a_r10_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(base_q));

    // R4: a narrow request never carries mask bits above the first lane.
    a_r4_narrow_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && narrow_q) |-> (mask_q[NB-1] == '0));

endmodule

// File: rtl/tbm_alu.sv
// Combinational test-and-modify datapath: zero test of operand AND mask,
// and the clear (operand AND NOT mask) or set (operand OR mask) result.
// Assumes: inputs are registered values held stable during the write phase.
module tbm_alu
    import tbm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd_i,
    input  logic [W-1:0] mask_i,
    input  tbm_op_e      op_i,
    output logic [W-1:0] result_o,
    output logic         zero_o
);

    // Test the original value and form the write-back value.
    always_comb begin
        zero_o   = ((opnd_i & mask_i) == '0);
        result_o = (op_i == OP_SET) ? (opnd_i | mask_i) : (opnd_i & ~mask_i);
    end

endmodule

// File: rtl/tbm_unit.sv
// Top of the bit test-and-modify unit. Reads an 8- or 16-bit operand byte
// by byte, records whether mask AND operand was zero, then writes back the
// operand with the masked bits cleared or set.
// Assumes: a synchronous byte memory with one-cycle read latency; the
// address for the high byte wraps modulo 2^AW.
module tbm_unit
    import tbm_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_set,
    input  logic          narrow,
    input  logic [2*DW-1:0] mask,
    input  logic [AW-1:0] addr,
    output logic          busy,
    output logic          done,
    output logic          zero,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int NB  = 2;
    localparam int OPW = NB * DW;

    logic            load, sel_hi, cap_lo, cap_hi, upd_z;
    logic [AW-1:0]   base;
    tbm_op_e         op_q;
    logic            narrow_q;
    logic [OPW-1:0]  mask_q, opnd, result;
    logic            alu_zero, zero_q;
    logic [DW-1:0]   wr_mask_byte;

    tbm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .narrow_i (narrow_q),
        .load_o   (load),
        .busy_o   (busy),
        .done_o   (done),
        .rd_o     (mem_rd),
        .wr_o     (mem_wr),
        .sel_hi_o (sel_hi),
        .cap_lo_o (cap_lo),
        .cap_hi_o (cap_hi),
        .upd_z_o  (upd_z)
    );

    tbm_opreg #(.AW(AW), .DW(DW), .NB(NB)) u_opreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .busy_i   (busy),
        .addr_i   (addr),
        .mask_i   (mask),
        .op_set_i (op_set),
        .narrow_i (narrow),
        .cap_i    ({cap_hi, cap_lo}),
        .rdata_i  (mem_rdata),
        .base_o   (base),
        .op_o     (op_q),
        .narrow_o (narrow_q),
        .mask_o   (mask_q),
        .opnd_o   (opnd)
    );

    tbm_alu #(.W(OPW)) u_alu (
        .opnd_i   (opnd),
        .mask_i   (mask_q),
        .op_i     (op_q),
        .result_o (result),
        .zero_o   (alu_zero)
    );

    // Hold the zero flag between operations; update it in the compute step.
    always_ff @(posedge clk) begin
        if (!rst_n)     zero_q <= 1'b0;
        else if (upd_z) zero_q <= alu_zero;
    end

    // Steer the byte address, write data and the mask byte for the checks.
    always_comb begin
        mem_addr     = sel_hi ? base + AW'(1) : base;
        mem_wdata    = sel_hi ? result[OPW-1 -: DW] : result[DW-1:0];
        wr_mask_byte = sel_hi ? mask_q[OPW-1 -: DW] : mask_q[DW-1:0];
    end

    assign zero = zero_q;

    // R2: a clear write carries no bit that the mask selects.
    a_r2_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && op_q == OP_CLEAR) |-> ((mem_wdata & wr_mask_byte) == '0));

    // R3: a set write carries every bit that the mask selects.
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && op_q == OP_SET) |-> ((mem_wdata & wr_mask_byte) == wr_mask_byte));

    // R5: the high byte is written right after the low byte.
    a_r5_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && sel_hi) |-> ($past(mem_wr) && !$past(sel_hi)));

    // R4: narrow operations never touch the next address.
    a_r4_no_hi_access: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_q |-> !((mem_rd || mem_wr) && sel_hi));

endmodule

// File: tb/tb_tbm_unit.sv
module tb_tbm_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_set = 1'b0;
    logic        narrow = 1'b0;
    logic [15:0] mask = '0;
    logic [15:0] addr = '0;
    logic        busy, done, zero, mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int wr_n   = 0;
    logic [15:0] wr_log [4];
    logic [7:0]  mem [logic [15:0]];

    always #2 clk = ~clk;

    tbm_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_set(op_set),
        .narrow(narrow), .mask(mask), .addr(addr), .busy(busy),
        .done(done), .zero(zero), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Byte memory model: one-cycle read latency, logs write addresses.
    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr] = mem_wdata;
            if (wr_n < 4) wr_log[wr_n] = mem_addr;
            wr_n = wr_n + 1;
        end
        if (mem_rd) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // Fields: addr, initial {hi,lo}, mask, set, narrow, expected {hi,lo}, expected zero
    localparam int NV = 9;
    localparam logic [66:0] VECS [NV] = '{
        {16'h0010, 16'h00A5, 16'h0002, 1'b0, 1'b1, 16'h00A5, 1'b1},
        {16'h0020, 16'h003C, 16'h0004, 1'b0, 1'b1, 16'h0038, 1'b0},
        {16'h1234, 16'h0040, 16'h0081, 1'b1, 1'b1, 16'h00C1, 1'b1},
        {16'h8000, 16'h55F0, 16'hFF0F, 1'b1, 1'b1, 16'h55FF, 1'b1},
        {16'h4000, 16'h8001, 16'h8000, 1'b0, 1'b0, 16'h0001, 1'b0},
        {16'hABCD, 16'h0F00, 16'h00F0, 1'b1, 1'b0, 16'h0FF0, 1'b1},
        {16'hFFFF, 16'hFFFF, 16'h0F0F, 1'b0, 1'b0, 16'hF0F0, 1'b0},
        {16'h0100, 16'h1234, 16'h0000, 1'b1, 1'b0, 16'h1234, 1'b1},
        {16'h2000, 16'h00FF, 16'hFF00, 1'b0, 1'b0, 16'h00FF, 1'b1}
    };

    // Issue one operation and return the edge count until done (R7 busy check inside).
    task automatic run_op(input logic [15:0] a, input logic [15:0] m,
                          input logic s, input logic nr, output int n);
        @(negedge clk);
        addr = a; mask = m; op_set = s; narrow = nr; start = 1'b1; wr_n = 0;
        @(posedge clk); #1;
        start = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            chk(busy === 1'b1, "R7 busy during op", {31'd0, busy}, 1);
            @(posedge clk); #1;
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(posedge clk);
        #1;
        // R9: state after reset.
        chk({busy, done, mem_rd, mem_wr, zero} == 5'b0, "R9 reset outputs",
            {27'd0, busy, done, mem_rd, mem_wr, zero}, 0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [15:0] va, vi, vm, ve;
            logic vs, vn, vz;
            {va, vi, vm, vs, vn, ve, vz} = VECS[i];
            mem[va]         = vi[7:0];
            mem[va + 16'd1] = vi[15:8];
            run_op(va, vm, vs, vn, n);
            chk(n == (vn ? 5 : 7), "R7 latency", n, vn ? 5 : 7);
            chk(zero == vz, "R1 zero flag", {31'd0, zero}, {31'd0, vz});
            chk(rd(va) == ve[7:0], vs ? "R3 low byte" : "R2 low byte", rd(va), ve[7:0]);
            chk(rd(va + 16'd1) == ve[15:8], vn ? "R4 next byte untouched" : "R5 high byte",
                rd(va + 16'd1), ve[15:8]);
            chk(wr_n == (vn ? 1 : 2), "R8 write count", wr_n, vn ? 1 : 2);
            chk(wr_log[0] == va, "R6 write address", wr_log[0], va);
            if (!vn)
                chk(wr_log[1] == va + 16'd1, "R5 high write order", wr_log[1], va + 16'd1);
            @(posedge clk); #1;
            chk(!busy && !done, "R7 idle after done", {30'd0, busy, done}, 0);
            chk(zero == vz, "R1 zero held", {31'd0, zero}, {31'd0, vz});
        end

        // R10: a second start while busy is ignored.
        mem[16'h3000] = 8'h00;
        mem[16'h3100] = 8'h77;
        @(negedge clk);
        addr = 16'h3000; mask = 16'h0001; op_set = 1'b1; narrow = 1'b1;
        start = 1'b1; wr_n = 0;
        @(posedge clk); #1;
        start = 1'b0;
        @(posedge clk); #1;
        addr = 16'h3100; mask = 16'h00FF; op_set = 1'b0; narrow = 1'b0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 0;
        while (!done && n < 20) begin @(posedge clk); #1; n++; end
        chk(rd(16'h3000) == 8'h01, "R10 running op kept its request", rd(16'h3000), 8'h01);
        chk(rd(16'h3100) == 8'h77, "R10 ignored start", rd(16'h3100), 8'h77);
        chk(wr_n == 1, "R10 single write", wr_n, 1);
        @(posedge clk); #1;
        chk(!busy, "R10 no second op", {31'd0, busy}, 0);

        // R9: reset in the middle of a wide operation.
        mem[16'h5000] = 8'h0F;
        mem[16'h5001] = 8'hF0;
        @(negedge clk);
        addr = 16'h5000; mask = 16'h0101; op_set = 1'b0; narrow = 1'b0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(zero == 1'b0, "R1 zero updated mid-op", {31'd0, zero}, 0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk({busy, done, mem_rd, mem_wr, zero} == 5'b0, "R9 mid-op reset",
            {27'd0, busy, done, mem_rd, mem_wr, zero}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(!busy, "R9 stays idle", {31'd0, busy}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule